// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block couples two parallel data buses, called A and B, through a pair of direction paths. Each path owns a storage register that samples its source bus on a clock edge when its load strobe is high. A per-path select decides what goes out on the far bus: the live value arriving on the near bus, or the value held in that path's register. Bus pins are modelled as a separate input vector, output vector and output-enable bit per bus, so a pad ring or an on-chip bus fabric resolves the physical sharing.

Two elaboration parameters shape the block. `CTL_STYLE` picks how the two control pins `ctrl_a` and `ctrl_b` are read. In the shared style, `ctrl_a` is an active-low enable for the whole transceiver and `ctrl_b` is a direction bit. In the split style, `ctrl_a` is an active-high enable for the B bus and `ctrl_b` is an active-low enable for the A bus. `INVERT` makes both output paths present the complement of their data. When a bus is being driven by the block, its register samples the driven value rather than the external input. A register can therefore copy the opposite bus through the transceiver.

Top module: `regbus_xcvr`

## Requirements
- R1: On a rising `clk` edge with `ld_ab` high, the A-to-B register takes the A bus value. On a rising `clk` edge with `ld_ba` high, the B-to-A register takes the B bus value. With its strobe low, a register holds its value.
- R2: Register loading does not depend on `sel_ab`, `sel_ba`, `ctrl_a` or `ctrl_b`. A value loaded while both buses are isolated is the one later presented.
- R3: For each path, select 0 presents the live opposite-bus input and select 1 presents that path's register. The choice is combinational, so a select change shows in the same cycle with no clock edge.
- R4: Shared style: `ctrl_a` = 1 drives neither bus (`a_oe` = `b_oe` = 0).
- R5: Shared style with `ctrl_a` = 0: `ctrl_b` = 1 drives B from the A-to-B path, and `ctrl_b` = 0 drives A from the B-to-A path.
- R6: Shared style: `a_oe` and `b_oe` are never both 1.
- R7: Split style: `b_oe` equals `ctrl_a` and `a_oe` equals the inverse of `ctrl_b`. With `ctrl_a` = 1 and `ctrl_b` = 0, both buses are driven at once, each from its own path.
- R8: While a bus is driven by the block (its oe = 1), the register that loads from that bus samples the driven output value, not the external input.
- R9: With `INVERT` = 1, the output bus carries the bitwise complement on both the live and the stored path.
- R10: An active-low asynchronous `rst_n` clears both registers to all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_a | input | 1 | Shared: active-low enable. Split: B-bus enable, active high |
| ctrl_b | input | 1 | Shared: direction (1 = A to B). Split: A-bus enable, active low |
| sel_ab | input | 1 | A-to-B source: 0 live, 1 stored |
| sel_ba | input | 1 | B-to-A source: 0 live, 1 stored |
| ld_ab | input | 1 | Load strobe of the A-to-B register |
| ld_ba | input | 1 | Load strobe of the B-to-A register |
| a_in | input | W | Value arriving on bus A |
| a_out | output | W | Value the block drives onto bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_in | input | W | Value arriving on bus B |
| b_out | output | W | Value the block drives onto bus B |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
A wrong register value stays hidden until the path is selected for stored data and its bus is enabled. At that point it appears on the output vector in the same cycle, so the bench always reads registers back through a stored-select window after each load. A bad enable decode shows up at once on `a_oe`/`b_oe` for the offending control pattern. A register that samples the external input instead of the driven value only becomes visible one load later, when the stored copy is selected onto the other bus.

// File: rtl/regbus_xcvr_pkg.sv
package regbus_xcvr_pkg;

   // How the two control pins of the transceiver are decoded
   typedef enum logic {
      CTL_SHARED = 1'b0,  // ctrl_a: enable (active low), ctrl_b: direction
      CTL_SPLIT  = 1'b1   // ctrl_a: B enable (high), ctrl_b: A enable (low)
   } ctl_style_e;

endpackage

// File: rtl/regbus_xcvr_oe_dec.sv
module regbus_xcvr_oe_dec
   import regbus_xcvr_pkg::*;
#(
   parameter ctl_style_e CTL_STYLE = CTL_SHARED
) (
   input  logic ctrl_a,
   input  logic ctrl_b,
   output logic oe_a,
   output logic oe_b
);

   generate
      if (CTL_STYLE == CTL_SHARED) begin : g_shared
         // one enable gates both, direction picks exactly one bus
         always_comb begin
            oe_a = 1'b0;
            oe_b = 1'b0;
            if (!ctrl_a) begin
               oe_b = ctrl_b;
               oe_a = !ctrl_b;
            end
         end
      end else begin : g_split
         // independent enables with opposite polarity
         always_comb begin
            oe_b = ctrl_a;
            oe_a = !ctrl_b;
         end
      end
   endgenerate

endmodule

// File: rtl/regbus_xcvr_lane.sv
module regbus_xcvr_lane #(
   parameter int unsigned W      = 8,
   parameter bit          INVERT = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic         sel,
   input  logic [W-1:0] cap_d,
   input  logic [W-1:0] live_d,
   output logic [W-1:0] out_d
);

   localparam logic [W-1:0] ZERO = '0;

   logic [W-1:0] held_q;
   logic [W-1:0] pick;

   // storage register, loads on strobe regardless of output controls
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q <= ZERO;
      end else if (ld) begin
         held_q <= cap_d;
      end
   end

   // combinational source select: no extra stage between select and bus
   always_comb begin
      pick = sel ? held_q : live_d;
   end

   generate
      if (INVERT) begin : g_inv
         assign out_d = ~pick;
      end else begin : g_true
         assign out_d = pick;
      end
   endgenerate

endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
   import regbus_xcvr_pkg::*;
#(
   parameter int unsigned W         = 8,
   parameter ctl_style_e  CTL_STYLE = CTL_SHARED,
   parameter bit          INVERT    = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ctrl_a,
   input  logic         ctrl_b,
   input  logic         sel_ab,
   input  logic         sel_ba,
   input  logic         ld_ab,
   input  logic         ld_ba,
   input  logic [W-1:0] a_in,
   output logic [W-1:0] a_out,
   output logic         a_oe,
   input  logic [W-1:0] b_in,
   output logic [W-1:0] b_out,
   output logic         b_oe
);

   localparam int unsigned MAX_W = 1024;

   generate
      if (W < 1 || W > MAX_W) begin : g_bad_width
         $error("regbus_xcvr: W must lie in 1..%0d", MAX_W);
      end
   endgenerate

   // resolved bus values: what a register on each bus really sees
   logic [W-1:0] a_bus;
   logic [W-1:0] b_bus;

   always_comb begin
      a_bus = a_oe ? a_out : a_in;
      b_bus = b_oe ? b_out : b_in;
   end

   regbus_xcvr_oe_dec #(
      .CTL_STYLE (CTL_STYLE)
   ) u_dec (
      .ctrl_a (ctrl_a),
      .ctrl_b (ctrl_b),
      .oe_a   (a_oe),
      .oe_b   (b_oe)
   );

   // A to B: samples bus A, live source is the A input
   regbus_xcvr_lane #(
      .W      (W),
      .INVERT (INVERT)
   ) u_lane_ab (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (ld_ab),
      .sel    (sel_ab),
      .cap_d  (a_bus),
      .live_d (a_in),
      .out_d  (b_out)
   );

   // B to A: samples bus B, live source is the B input
   regbus_xcvr_lane #(
      .W      (W),
      .INVERT (INVERT)
   ) u_lane_ba (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (ld_ba),
      .sel    (sel_ba),
      .cap_d  (b_bus),
      .live_d (b_in),
      .out_d  (a_out)
   );

endmodule

// File: rtl/regbus_xcvr_chk.sv
module regbus_xcvr_chk
   import regbus_xcvr_pkg::*;
#(
   parameter int unsigned W         = 8,
   parameter ctl_style_e  CTL_STYLE = CTL_SHARED,
   parameter bit          INVERT    = 1'b0
) (
   input logic         clk,
   input logic         rst_n,
   input logic         ctrl_a,
   input logic         ctrl_b,
   input logic         sel_ab,
   input logic         sel_ba,
   input logic         ld_ab,
   input logic         ld_ba,
   input logic [W-1:0] a_in,
   input logic [W-1:0] a_out,
   input logic         a_oe,
   input logic [W-1:0] b_in,
   input logic [W-1:0] b_out,
   input logic         b_oe
);

   function automatic logic [W-1:0] shown(input logic [W-1:0] v);
      return INVERT ? ~v : v;
   endfunction

   generate
      if (CTL_STYLE == CTL_SHARED) begin : g_shared
         // R4
         p_isolate_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ctrl_a |-> (!a_oe && !b_oe));
         // R6
         p_one_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !(a_oe && b_oe));
         // R5
         p_direction_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !ctrl_a |-> (b_oe == ctrl_b));
      end else begin : g_split
         // R7
         p_split_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (b_oe == ctrl_a) && (a_oe == !ctrl_b));
      end
   endgenerate

   // R3 / R9: live path follows the opposite input
   p_live_ab_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (b_oe && !sel_ab) |-> (b_out == shown(a_in)));
   p_live_ba_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (a_oe && !sel_ba) |-> (a_out == shown(b_in)));

   // R1: stored value is held without a strobe
   p_hold_ab_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (b_oe && sel_ab && $past(b_oe && sel_ab) && !$past(ld_ab)) |-> $stable(b_out));
   p_hold_ba_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (a_oe && sel_ba && $past(a_oe && sel_ba) && !$past(ld_ba)) |-> $stable(a_out));

   // R8: a load takes the resolved bus value
   p_load_ab_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (b_oe && sel_ab && $past(ld_ab) && $past(rst_n))
         |-> (b_out == shown($past(a_oe ? a_out : a_in))));
   p_load_ba_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (a_oe && sel_ba && $past(ld_ba) && $past(rst_n))
         |-> (a_out == shown($past(b_oe ? b_out : b_in))));

endmodule

bind regbus_xcvr regbus_xcvr_chk #(
   .W         (W),
   .CTL_STYLE (CTL_STYLE),
   .INVERT    (INVERT)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .ctrl_a (ctrl_a),
   .ctrl_b (ctrl_b),
   .sel_ab (sel_ab),
   .sel_ba (sel_ba),
   .ld_ab  (ld_ab),
   .ld_ba  (ld_ba),
   .a_in   (a_in),
   .a_out  (a_out),
   .a_oe   (a_oe),
   .b_in   (b_in),
   .b_out  (b_out),
   .b_oe   (b_oe)
);

// File: tb/regbus_xcvr_test.sv
module regbus_xcvr_test;
   import regbus_xcvr_pkg::*;

   localparam int PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(PERIOD/2) clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;

   // shared-style, non-inverting instance
   logic ctrl_a, ctrl_b, sel_ab, sel_ba, ld_ab, ld_ba;
   logic [7:0] a_in, a_out, b_in, b_out;
   logic a_oe, b_oe;

   // split-style, inverting instance
   logic d_ctrl_a, d_ctrl_b, d_sel_ab, d_sel_ba, d_ld_ab, d_ld_ba;
   logic [7:0] d_a_in, d_a_out, d_b_in, d_b_out;
   logic d_a_oe, d_b_oe;

   regbus_xcvr #(.W(8), .CTL_STYLE(CTL_SHARED), .INVERT(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .ctrl_a(ctrl_a), .ctrl_b(ctrl_b),
      .sel_ab(sel_ab), .sel_ba(sel_ba), .ld_ab(ld_ab), .ld_ba(ld_ba),
      .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
      .b_in(b_in), .b_out(b_out), .b_oe(b_oe));

   regbus_xcvr #(.W(8), .CTL_STYLE(CTL_SPLIT), .INVERT(1'b1)) uut2 (
      .clk(clk), .rst_n(rst_n), .ctrl_a(d_ctrl_a), .ctrl_b(d_ctrl_b),
      .sel_ab(d_sel_ab), .sel_ba(d_sel_ba), .ld_ab(d_ld_ab), .ld_ba(d_ld_ba),
      .a_in(d_a_in), .a_out(d_a_out), .a_oe(d_a_oe),
      .b_in(d_b_in), .b_out(d_b_out), .b_oe(d_b_oe));

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
   endtask

   // one-cycle strobe: raised at a falling edge, taken at the next rising edge
   task automatic strobe(input bit ab, input bit ba, input bit dual);
      @(negedge clk);
      if (dual) begin d_ld_ab = ab; d_ld_ba = ba; end
      else      begin ld_ab = ab;   ld_ba = ba;   end
      @(negedge clk);
      ld_ab = 0; ld_ba = 0; d_ld_ab = 0; d_ld_ba = 0;
      #1;
   endtask

   task automatic t_reset();
      // R10: stored paths show zero during and after reset
      ctrl_a = 0; ctrl_b = 1; sel_ab = 1; sel_ba = 1;
      #1;
      chk("R10 b_out in reset", b_out, 8'h00);
      @(negedge clk) rst_n = 1;
      #1;
      chk("R10 b_out after reset", b_out, 8'h00);
      ctrl_b = 0; #1;
      chk("R10 a_out after reset", a_out, 8'h00);
   endtask

   task automatic t_live();
      ctrl_a = 0; ctrl_b = 1; sel_ab = 0; a_in = 8'h3C; b_in = 8'h77; #1;
      chk("R5 b_oe dir=1", {7'd0, b_oe}, 8'h01);
      chk("R6 a_oe dir=1", {7'd0, a_oe}, 8'h00);
      chk("R3 live A to B", b_out, 8'h3C);
      ctrl_b = 0; sel_ba = 0; b_in = 8'hA5; #1;
      chk("R5 a_oe dir=0", {7'd0, a_oe}, 8'h01);
      chk("R6 b_oe dir=0", {7'd0, b_oe}, 8'h00);
      chk("R3 live B to A", a_out, 8'hA5);
   endtask

   task automatic t_stored();
      ctrl_a = 0; ctrl_b = 1; sel_ab = 1; a_in = 8'h5A;
      strobe(1, 0, 0);
      chk("R1 stored A to B", b_out, 8'h5A);
      a_in = 8'hFF;
      @(negedge clk); @(negedge clk); #1;
      chk("R1 hold without strobe", b_out, 8'h5A);
      sel_ab = 0; #1;
      chk("R3 select takes effect without clock", b_out, 8'hFF);
      sel_ab = 1; #1;
      chk("R3 select back to stored", b_out, 8'h5A);
   endtask

   task automatic t_isolate_load();
      ctrl_a = 1; ctrl_b = 1; a_in = 8'h11; b_in = 8'h22; #1;
      chk("R4 a_oe isolated", {7'd0, a_oe}, 8'h00);
      chk("R4 b_oe isolated", {7'd0, b_oe}, 8'h00);
      strobe(1, 1, 0);
      chk("R4 still isolated after load", {6'd0, a_oe, b_oe}, 8'h00);
      a_in = 8'h00; b_in = 8'h00;
      ctrl_a = 0; ctrl_b = 1; sel_ab = 1; #1;
      chk("R2 A register loaded while isolated", b_out, 8'h11);
      ctrl_b = 0; sel_ba = 1; #1;
      chk("R2 B register loaded while isolated", a_out, 8'h22);
   endtask

   task automatic t_split_capture();
      chk("R7 both off", {6'd0, d_a_oe, d_b_oe}, 8'h00);
      d_ctrl_a = 1; d_sel_ab = 0; d_a_in = 8'h0F; d_b_in = 8'h33; #1;
      chk("R7 b_oe follows ctrl_a", {7'd0, d_b_oe}, 8'h01);
      chk("R9 inverted live A to B", d_b_out, 8'hF0);
      strobe(0, 1, 1);
      d_ctrl_a = 0; d_ctrl_b = 0; d_sel_ba = 1; #1;
      chk("R7 a_oe from ctrl_b low", {6'd0, d_a_oe, d_b_oe}, 8'h02);
      chk("R8 B register took driven value", d_a_out, 8'h0F);
      d_sel_ba = 0; #1;
      chk("R9 inverted live B to A", d_a_out, 8'hCC);
   endtask

   task automatic t_split_both();
      d_ctrl_a = 0; d_ctrl_b = 1; d_a_in = 8'h81; d_b_in = 8'h42;
      strobe(1, 1, 1);
      d_ctrl_a = 1; d_ctrl_b = 0; d_sel_ab = 1; d_sel_ba = 1; #1;
      chk("R7 both buses driven", {6'd0, d_a_oe, d_b_oe}, 8'h03);
      chk("R9 inverted stored A to B", d_b_out, 8'h7E);
      chk("R9 inverted stored B to A", d_a_out, 8'hBD);
      d_a_in = 8'h00; #1;
      chk("R3 stored path ignores live input", d_b_out, 8'h7E);
   endtask

   initial begin
      #(PERIOD * 2000);
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      ctrl_a = 1; ctrl_b = 0; sel_ab = 0; sel_ba = 0; ld_ab = 0; ld_ba = 0;
      a_in = 8'h00; b_in = 8'h00;
      d_ctrl_a = 0; d_ctrl_b = 1; d_sel_ab = 0; d_sel_ba = 0;
      d_ld_ab = 0; d_ld_ba = 0; d_a_in = 8'h00; d_b_in = 8'h00;
      repeat (3) @(negedge clk);
      t_reset();
      t_live();
      t_stored();
      t_isolate_load();
      t_split_capture();
      t_split_both();
      @(negedge clk);
      summary();
      $finish;
   end

endmodule